// File: doc/BRIEF.md
# Vector Broadcast Execution Unit

This unit performs vector broadcast operations into a 256-bit destination register. A decoded operation code picks the element size: a 32-bit element, a 64-bit element, or a 128-bit block. The unit copies the low element of a source value of up to 128 bits into every slot of the destination. A vector-length bit chooses between a full 256-bit result and a 128-bit result. For the 128-bit length the upper half of the destination is forced to zero.

Before any result is written, the unit checks the encoding fields that come with the instruction. These are a width bit, a four-bit spare operand field, the vector-length bit and a register-versus-memory source flag. An illegal combination raises an undefined-opcode fault. A faulting operation never writes: the write enable stays low and the result bus reads zero. The outputs pass through a register stage, which a parameter can remove. In the default build every result appears one clock after its operands are presented.

Top module: `vec_bcast_unit`

## Requirements
- R1: With opSel=2'b00 (32-bit element) and lenBit=1, result holds srcData[31:0] in all eight 32-bit lanes.
- R2: With lenBit=0, the 32-bit broadcast fills lanes 0 to 3 (bits 127:0) with srcData[31:0] and result[255:128] is zero.
- R3: With opSel=2'b01 (64-bit element) and lenBit=1, result holds srcData[63:0] in all four 64-bit lanes, for a register source (srcIsReg=1) or a memory source (srcIsReg=0).
- R4: With opSel=2'b10 (128-bit block), lenBit=1 and a memory source (srcIsReg=0), result[127:0] and result[255:128] both equal srcData[127:0].
- R5: Any valid operation whose extraField is not 4'b1111 faults.
- R6: Any valid operation with widthBit=1 faults.
- R7: The 64-bit and 128-bit broadcasts fault when lenBit=0.
- R8: The 128-bit broadcast faults when srcIsReg=1.
- R9: opSel=2'b11 is reserved and always faults.
- R10: A faulting operation gives udFault=1, wrEn=0 and result zero. When inValid=0, all three outputs are zero. A legal operation gives wrEn=1 and udFault=0.
- R11: With OUT_REG=1, the outputs reflect the inputs sampled at the previous rising clock edge. Asynchronous reset (rst_n low) clears wrEn, udFault and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 2 | 00 = 32-bit, 01 = 64-bit, 10 = 128-bit, 11 = reserved |
| lenBit | input | 1 | 1 = 256-bit result, 0 = 128-bit result |
| widthBit | input | 1 | Width bit; must be 0 |
| extraField | input | 4 | Spare operand field; must be 4'b1111 |
| srcIsReg | input | 1 | 1 = register source, 0 = memory source |
| srcData | input | 128 | Source value |
| wrEn | output | 1 | Destination write enable |
| udFault | output | 1 | Undefined-opcode fault |
| result | output | 256 | Broadcast result |

## Verification
Every output is due on the rising edge that follows the edge at which its operands are sampled, because a single register stage sits between the combinational logic and the ports. The bench changes the inputs on a falling edge and waits for the next rising edge. It samples one time unit later, so each check reads exactly the cycle that belongs to its stimulus. Idle checks drop inValid for one cycle and look at that next cycle. This shows that a result does not persist past its own slot.

// File: rtl/vec_bcast_pkg.sv
package vec_bcast_pkg;

  typedef enum logic [1:0] {
    OP_B32  = 2'b00,
    OP_B64  = 2'b01,
    OP_B128 = 2'b10,
    OP_RSVD = 2'b11
  } bcast_op_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic rep32;
    logic rep64;
    logic rep128;
    logic upperZero;
    logic kill;
    logic wrEn;
    logic fault;
  } bcast_stb_t;

endpackage

// File: rtl/vec_bcast_ctrl.sv
module vec_bcast_ctrl
  import vec_bcast_pkg::*;
#(
  parameter int XF_W = 4
) (
  input  logic            inValid,
  input  logic [1:0]      opSel,
  input  logic            lenBit,
  input  logic            widthBit,
  input  logic [XF_W-1:0] extraField,
  input  logic            srcIsReg,
  output bcast_stb_t      stb
);

  localparam logic [XF_W-1:0] XF_OK = '1;

  bcast_op_e opCode;
  logic xfBad, wBad, lenBad, regBad, rsvBad, anyBad;

  assign opCode = bcast_op_e'(opSel);

  always_comb begin
    xfBad  = (extraField != XF_OK);
    wBad   = widthBit;
    rsvBad = (opCode == OP_RSVD);
    lenBad = ((opCode == OP_B64) || (opCode == OP_B128)) && !lenBit;
    regBad = (opCode == OP_B128) && srcIsReg;
    anyBad = xfBad | wBad | rsvBad | lenBad | regBad;
  end

  always_comb begin
    stb           = '0;
    stb.fault     = inValid & anyBad;
    stb.wrEn      = inValid & ~anyBad;
    stb.kill      = ~stb.wrEn;
    stb.upperZero = ~lenBit;
    unique case (opCode)
      OP_B32:  stb.rep32  = 1'b1;
      OP_B64:  stb.rep64  = 1'b1;
      OP_B128: stb.rep128 = 1'b1;
      default: stb.kill   = 1'b1;
    endcase
  end

endmodule

// File: rtl/vec_bcast_dp.sv
module vec_bcast_dp
  import vec_bcast_pkg::*;
#(
  parameter int SRC_W  = 128,
  parameter int DST_W  = 256,
  parameter int LANE_W = 32
) (
  input  bcast_stb_t        stb,
  input  logic [SRC_W-1:0]  srcData,
  output logic [DST_W-1:0]  dpOut
);

  localparam int LANES     = DST_W / LANE_W;
  localparam int PER64     = 64 / LANE_W;
  localparam int PER128    = SRC_W / LANE_W;
  localparam int HALF      = LANES / 2;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit IS_HIGH = (i >= HALF);
    logic [LANE_W-1:0] laneVal;

    always_comb begin
      laneVal = '0;
      if (stb.rep32)
        laneVal = srcData[0 +: LANE_W];
      else if (stb.rep64)
        laneVal = srcData[(i % PER64) * LANE_W +: LANE_W];
      else if (stb.rep128)
        laneVal = srcData[(i % PER128) * LANE_W +: LANE_W];
      if (stb.kill || (IS_HIGH && stb.upperZero))
        laneVal = '0;
    end

    assign dpOut[i*LANE_W +: LANE_W] = laneVal;
  end

endmodule

// File: rtl/vec_bcast_unit.sv
module vec_bcast_unit
  import vec_bcast_pkg::*;
#(
  parameter int SRC_W   = 128,
  parameter int DST_W   = 256,
  parameter int LANE_W  = 32,
  parameter int XF_W    = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic              lenBit,
  input  logic              widthBit,
  input  logic [XF_W-1:0]   extraField,
  input  logic              srcIsReg,
  input  logic [SRC_W-1:0]  srcData,
  output logic              wrEn,
  output logic              udFault,
  output logic [DST_W-1:0]  result
);

  localparam int HALF_W = DST_W / 2;

  bcast_stb_t        stb;
  logic [DST_W-1:0]  dpOut;

  vec_bcast_ctrl #(.XF_W(XF_W)) i_ctrl (
    .inValid    (inValid),
    .opSel      (opSel),
    .lenBit     (lenBit),
    .widthBit   (widthBit),
    .extraField (extraField),
    .srcIsReg   (srcIsReg),
    .stb        (stb)
  );

  vec_bcast_dp #(.SRC_W(SRC_W), .DST_W(DST_W), .LANE_W(LANE_W)) i_dp (
    .stb     (stb),
    .srcData (srcData),
    .dpOut   (dpOut)
  );

  if (OUT_REG) begin : g_reg
    logic pastOk;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wrEn    <= 1'b0;
        udFault <= 1'b0;
        result  <= '0;
        pastOk  <= 1'b0;
      end else begin
        wrEn    <= stb.wrEn;
        udFault <= stb.fault;
        result  <= dpOut;
        pastOk  <= 1'b1;
      end
    end

    assert_fault_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
      udFault |-> (!wrEn && result == '0));

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wrEn, udFault}));

    assert_xfield_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pastOk && $past(inValid && extraField != '1) |-> udFault);

    assert_wbit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pastOk && $past(inValid && widthBit) |-> udFault);

    assert_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pastOk && $past(inValid && opSel == 2'b11) |-> udFault);

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pastOk && $past(!lenBit) |-> (result[DST_W-1:HALF_W] == '0));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pastOk && $past(!inValid) |-> (!wrEn && !udFault));
  end else begin : g_comb
    assign wrEn    = stb.wrEn;
    assign udFault = stb.fault;
    assign result  = dpOut;
  end

endmodule

// File: tb/test_vec_bcast_unit.sv
`timescale 1ns/1ps
module test_vec_bcast_unit;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         inValid;
  logic [1:0]   opSel;
  logic         lenBit, widthBit, srcIsReg;
  logic [3:0]   extraField;
  logic [127:0] srcData;
  logic         wrEn, udFault;
  logic [255:0] result;

  int testsRun = 0;
  int testsFail = 0;

  always #2 clk = ~clk;  // 250 MHz

  vec_bcast_unit i_vec_bcast_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opSel(opSel),
    .lenBit(lenBit), .widthBit(widthBit), .extraField(extraField),
    .srcIsReg(srcIsReg), .srcData(srcData),
    .wrEn(wrEn), .udFault(udFault), .result(result)
  );

  localparam logic [127:0] PAT_A = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
  localparam logic [127:0] PAT_B = 128'hdead_beef_cafe_f00d_1357_9bdf_2468_ace0;

  task automatic check(string tag, logic expW, logic expF, logic [255:0] expR);
    testsRun++;
    if (wrEn !== expW || udFault !== expF || result !== expR) begin
      testsFail++;
      $display("FAIL %s: wrEn=%b udFault=%b result=%h expected wrEn=%b udFault=%b result=%h",
               tag, wrEn, udFault, result, expW, expF, expR);
    end
  endtask

  task automatic applyOp(logic v, logic [1:0] op, logic l, logic w, logic [3:0] xf,
                         logic rg, logic [127:0] src);
    @(negedge clk);
    inValid = v; opSel = op; lenBit = l; widthBit = w;
    extraField = xf; srcIsReg = rg; srcData = src;
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    check("R11 reset", 1'b0, 1'b0, '0);
  endtask

  task automatic testB32Long();
    applyOp(1, 2'b00, 1, 0, 4'hF, 0, PAT_A);
    check("R1 b32 L1 mem", 1, 0, {8{PAT_A[31:0]}});
    applyOp(1, 2'b00, 1, 0, 4'hF, 1, PAT_B);
    check("R1 b32 L1 reg", 1, 0, {8{PAT_B[31:0]}});
  endtask

  task automatic testB32Short();
    applyOp(1, 2'b00, 0, 0, 4'hF, 1, PAT_B);
    check("R2 b32 L0", 1, 0, {128'h0, {4{PAT_B[31:0]}}});
  endtask

  task automatic testB64();
    applyOp(1, 2'b01, 1, 0, 4'hF, 0, PAT_A);
    check("R3 b64 mem", 1, 0, {4{PAT_A[63:0]}});
    applyOp(1, 2'b01, 1, 0, 4'hF, 1, PAT_B);
    check("R3 b64 reg", 1, 0, {4{PAT_B[63:0]}});
  endtask

  task automatic testB128();
    applyOp(1, 2'b10, 1, 0, 4'hF, 0, PAT_B);
    check("R4 b128 mem", 1, 0, {2{PAT_B}});
  endtask

  task automatic testFaults();
    applyOp(1, 2'b00, 1, 0, 4'hE, 0, PAT_A);
    check("R5 xfield E", 0, 1, '0);
    applyOp(1, 2'b01, 1, 0, 4'h0, 0, PAT_A);
    check("R5 xfield 0", 0, 1, '0);
    applyOp(1, 2'b00, 1, 1, 4'hF, 0, PAT_A);
    check("R6 wbit b32", 0, 1, '0);
    applyOp(1, 2'b10, 1, 1, 4'hF, 0, PAT_A);
    check("R6 wbit b128", 0, 1, '0);
    applyOp(1, 2'b01, 0, 0, 4'hF, 0, PAT_A);
    check("R7 b64 L0", 0, 1, '0);
    applyOp(1, 2'b10, 0, 0, 4'hF, 0, PAT_A);
    check("R7 b128 L0", 0, 1, '0);
    applyOp(1, 2'b10, 1, 0, 4'hF, 1, PAT_A);
    check("R8 b128 reg", 0, 1, '0);
    applyOp(1, 2'b11, 1, 0, 4'hF, 0, PAT_A);
    check("R9 reserved", 0, 1, '0);
  endtask

  task automatic testIdle();
    applyOp(1, 2'b01, 1, 0, 4'hF, 0, PAT_B);
    check("R11 before idle", 1, 0, {4{PAT_B[63:0]}});
    applyOp(0, 2'b01, 1, 0, 4'hF, 0, PAT_B);
    check("R10 idle zero", 0, 0, '0);
    applyOp(0, 2'b11, 1, 1, 4'h0, 1, PAT_A);
    check("R10 idle bad fields", 0, 0, '0);
  endtask

  task automatic testBackToBack();
    applyOp(1, 2'b10, 0, 0, 4'hF, 0, PAT_A);
    check("R11 b2b fault", 0, 1, '0);
    applyOp(1, 2'b00, 1, 0, 4'hF, 0, PAT_A);
    check("R11 b2b legal", 1, 0, {8{PAT_A[31:0]}});
  endtask

  initial begin : watchdog
    #200000;
    testsRun++;
    testsFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; inValid = 0; opSel = 0; lenBit = 0; widthBit = 0;
    extraField = 4'hF; srcIsReg = 0; srcData = '0;
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rst_n = 1'b1;
    testB32Long();
    testB32Short();
    testB64();
    testB128();
    testFaults();
    testIdle();
    testBackToBack();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule